// File: doc/BRIEF.md
# Bit-Masked Output Flip-Flop Bank

This block keeps a bank of output flip-flops in groups of eight. Each group has a data byte and a protect byte. A flip-flop can change in two ways. Programmable logic can load it through a per-bit next-state value and load enable. A processor can also load it with a byte write to the group's data register. The protect byte stops processor writes to chosen bits. Bits that a logic state machine owns therefore keep their state when software writes the whole byte.

The processor sees a flat byte address space. The data registers of the groups come first, starting at `DATA_BASE`. The protect registers follow right after them. Reads are combinational: the read data path returns the current contents of the addressed register. Outputs of all flip-flops are presented in parallel, group by group.

Top module: `omc_bank`

## Requirements
- R1: Synchronous active-high reset clears every flip-flop and every protect register to 00h.
- R2: Data register of group g sits at offset 20h+g (20h for group 0, 21h for group 1). With its protect byte at 00h, a write loads all eight flip-flops, and a read returns their value.
- R3: Protect register of group g sits at offset 22h+g (22h for group 0, 23h for group 1). A write stores the byte, and a read returns it.
- R4: A protect bit at 1 blocks the processor write for that bit, and a bit at 0 lets it through. For example, with 0Fh in the protect byte, a byte write changes only bits 7:4.
- R5: When no processor write targets a group, each bit with its logic load enable high takes its logic next-state value on the next clock. Bits without the enable keep their value.
- R6: When an unprotected bit receives a processor write and a logic load in the same cycle, the processor data wins.
- R7: During a processor write, a protected bit still follows its logic load if that load is enabled, and holds otherwise.
- R8: A write to one group's data register changes no flip-flop of the other group.
- R9: A read of an unmapped offset returns 00h. A write to an unmapped offset changes no flip-flop and no protect register.
- R10: Bit i of group g appears at `cell_q[g*8+i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W (8) | Processor byte offset |
| cpu_wdata | input | GRP_W (8) | Processor write data |
| cpu_we | input | 1 | Processor write strobe, one cycle per write |
| cpu_rdata | output | GRP_W (8) | Combinational read data for cpu_addr |
| logic_d | input | NUM_GRP*GRP_W (16) | Logic next-state values, group-major |
| logic_ld | input | NUM_GRP*GRP_W (16) | Per-bit logic load enables |
| cell_q | output | NUM_GRP*GRP_W (16) | Flip-flop outputs, group-major |

## Verification
The bench builds the block with its default parameters: two groups of eight bits, an 8-bit offset and a base of 20h. These values put all four registers and the offsets on either side of them (1Fh, 24h) within reach. With two groups, the bench can show that a write to one group leaves the other untouched. It can also show that the protect bytes of the two groups act on their own groups only. Same-cycle collisions between logic loads and processor writes are driven on both protected and unprotected bits of one byte. This lets one write show both outcomes at once.

// File: rtl/omc_pkg.sv
package omc_pkg;

    localparam int DEF_GRP_W     = 8;
    localparam int DEF_NUM_GRP   = 2;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_DATA_BASE = 32'h20;

    // Source chosen for a flip-flop on the coming edge
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_CPU   = 2'd1,
        SRC_LOGIC = 2'd2
    } cell_src_e;

    // Per-bit control bundle seen by a cell
    typedef struct packed {
        logic cpu_wr;   // group data register written this cycle
        logic cpu_bit;  // processor data for this bit
        logic prot;     // protect bit
        logic lg_d;     // logic next-state value
        logic lg_ld;    // logic load enable
    } cell_ctl_t;

    // Priority: unprotected processor write, then logic load, then hold
    function automatic cell_src_e pick_src(input cell_ctl_t c);
        if (c.cpu_wr && !c.prot) begin
            return SRC_CPU;
        end else if (c.lg_ld) begin
            return SRC_LOGIC;
        end else begin
            return SRC_HOLD;
        end
    endfunction

    function automatic logic next_bit(input cell_src_e s, input cell_ctl_t c,
                                      input logic cur);
        case (s)
            SRC_CPU:   return c.cpu_bit;
            SRC_LOGIC: return c.lg_d;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/omc_decode.sv
module omc_decode #(
    parameter int ADDR_W    = omc_pkg::DEF_ADDR_W,
    parameter int NUM_GRP   = omc_pkg::DEF_NUM_GRP,
    parameter int DATA_BASE = omc_pkg::DEF_DATA_BASE
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    output logic [NUM_GRP-1:0] data_hit,
    output logic [NUM_GRP-1:0] mask_hit,
    output logic [NUM_GRP-1:0] data_we,
    output logic [NUM_GRP-1:0] mask_we,
    output logic               unmapped
);

    localparam int MASK_BASE = DATA_BASE + NUM_GRP;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] DOFF = ADDR_W'(DATA_BASE + g);
        localparam logic [ADDR_W-1:0] MOFF = ADDR_W'(MASK_BASE + g);
        assign data_hit[g] = (addr == DOFF);
        assign mask_hit[g] = (addr == MOFF);
        assign data_we[g]  = we && data_hit[g];
        assign mask_we[g]  = we && mask_hit[g];
    end

    assign unmapped = ~(|data_hit) && ~(|mask_hit);

endmodule

// File: rtl/omc_cell.sv
module omc_cell
    import omc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_ctl_t ctl,
    output logic      q
);

    cell_src_e src;
    logic      q_nxt;

    always_comb begin
        src   = pick_src(ctl);
        q_nxt = next_bit(src, ctl, q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= q_nxt;
        end
    end

    // R4: protected bit without logic load ignores the processor write
    a_r4_prot_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl.cpu_wr && ctl.prot && !ctl.lg_ld) |=> $stable(q));

    // R6: unprotected processor write wins over a logic load
    a_r6_cpu_wins: assert property (@(posedge clk) disable iff (rst)
        (ctl.cpu_wr && !ctl.prot) |=> (q == $past(ctl.cpu_bit)));

    // R7: protected bit keeps its logic load during a write
    a_r7_prot_logic: assert property (@(posedge clk) disable iff (rst)
        (ctl.cpu_wr && ctl.prot && ctl.lg_ld) |=> (q == $past(ctl.lg_d)));

    // R5: logic load with no write to the group
    a_r5_logic_load: assert property (@(posedge clk) disable iff (rst)
        (!ctl.cpu_wr && ctl.lg_ld) |=> (q == $past(ctl.lg_d)));

endmodule

// File: rtl/omc_group.sv
module omc_group
    import omc_pkg::*;
#(
    parameter int GRP_W = omc_pkg::DEF_GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_we,
    input  logic             mask_we,
    input  logic [GRP_W-1:0] wdata,
    input  logic [GRP_W-1:0] lg_d,
    input  logic [GRP_W-1:0] lg_ld,
    output logic [GRP_W-1:0] q,
    output logic [GRP_W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= wdata;
        end
    end

    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
        cell_ctl_t ctl;
        assign ctl.cpu_wr  = data_we;
        assign ctl.cpu_bit = wdata[i];
        assign ctl.prot    = mask[i];
        assign ctl.lg_d    = lg_d[i];
        assign ctl.lg_ld   = lg_ld[i];

        omc_cell u_cell (
            .clk (clk),
            .rst (rst),
            .ctl (ctl),
            .q   (q[i])
        );
    end

    // R3: protect register takes the written byte
    a_r3_mask_write: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask == $past(wdata)));

    // R3: protect register is stable without a write to it
    a_r3_mask_stable: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask));

endmodule

// File: rtl/omc_bank.sv
module omc_bank
    import omc_pkg::*;
#(
    parameter int GRP_W     = omc_pkg::DEF_GRP_W,
    parameter int NUM_GRP   = omc_pkg::DEF_NUM_GRP,
    parameter int ADDR_W    = omc_pkg::DEF_ADDR_W,
    parameter int DATA_BASE = omc_pkg::DEF_DATA_BASE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [GRP_W-1:0]           cpu_wdata,
    input  logic                       cpu_we,
    output logic [GRP_W-1:0]           cpu_rdata,
    input  logic [NUM_GRP*GRP_W-1:0]   logic_d,
    input  logic [NUM_GRP*GRP_W-1:0]   logic_ld,
    output logic [NUM_GRP*GRP_W-1:0]   cell_q
);

    localparam int TOT_W = NUM_GRP * GRP_W;

    logic [NUM_GRP-1:0] data_hit;
    logic [NUM_GRP-1:0] mask_hit;
    logic [NUM_GRP-1:0] data_we;
    logic [NUM_GRP-1:0] mask_we;
    logic               unmapped;

    logic [GRP_W-1:0] grp_q    [NUM_GRP];
    logic [GRP_W-1:0] grp_mask [NUM_GRP];

    omc_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_GRP   (NUM_GRP),
        .DATA_BASE (DATA_BASE)
    ) u_dec (
        .addr     (cpu_addr),
        .we       (cpu_we),
        .data_hit (data_hit),
        .mask_hit (mask_hit),
        .data_we  (data_we),
        .mask_we  (mask_we),
        .unmapped (unmapped)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        omc_group #(
            .GRP_W (GRP_W)
        ) u_grp (
            .clk     (clk),
            .rst     (rst),
            .data_we (data_we[g]),
            .mask_we (mask_we[g]),
            .wdata   (cpu_wdata),
            .lg_d    (logic_d[g*GRP_W +: GRP_W]),
            .lg_ld   (logic_ld[g*GRP_W +: GRP_W]),
            .q       (grp_q[g]),
            .mask    (grp_mask[g])
        );
        assign cell_q[g*GRP_W +: GRP_W] = grp_q[g];

        // R8: a group not written and not logic-loaded keeps its bits
        a_r8_group_isolated: assert property (@(posedge clk) disable iff (rst)
            (!data_we[g] && !(|logic_ld[g*GRP_W +: GRP_W]))
                |=> $stable(cell_q[g*GRP_W +: GRP_W]));
    end

    always_comb begin
        cpu_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (data_hit[g]) cpu_rdata = cpu_rdata | grp_q[g];
            if (mask_hit[g]) cpu_rdata = cpu_rdata | grp_mask[g];
        end
    end

    // R9: unmapped write with no logic load leaves all flip-flops alone
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && unmapped && !(|logic_ld)) |=> $stable(cell_q));

    // R9: unmapped read returns zero
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (cpu_rdata == '0));

    logic [TOT_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: tb/sim_omc_bank.sv
module sim_omc_bank;

    localparam int GW = 8;
    localparam int NG = 2;
    localparam int AW = 8;
    localparam int TW = NG * GW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic [GW-1:0] cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic [GW-1:0] cpu_rdata;
    logic [TW-1:0] logic_d = '0;
    logic [TW-1:0] logic_ld = '0;
    logic [TW-1:0] cell_q;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    omc_bank u0 (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .cpu_rdata (cpu_rdata),
        .logic_d   (logic_d),
        .logic_ld  (logic_ld),
        .cell_q    (cell_q)
    );

    task automatic chk(input string req, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [GW-1:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a,
                          input logic [GW-1:0] exp);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(req, TW'(cpu_rdata), TW'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 q", cell_q, 16'h0000);
        rd_chk("R1 data0", 8'h20, 8'h00);
        rd_chk("R1 data1", 8'h21, 8'h00);
        rd_chk("R1 mask0", 8'h22, 8'h00);
        rd_chk("R1 mask1", 8'h23, 8'h00);
    endtask

    task automatic t_full_write();
        wr(8'h20, 8'hA5);
        chk("R2 R10 group0 load", cell_q, 16'h00A5);
        chk("R8 group1 untouched", TW'(cell_q[15:8]), 16'h0000);
        wr(8'h21, 8'h3C);
        chk("R10 group1 position", cell_q, 16'h3CA5);
        rd_chk("R2 read data0", 8'h20, 8'hA5);
        rd_chk("R2 read data1", 8'h21, 8'h3C);
    endtask

    task automatic t_mask();
        wr(8'h22, 8'h0F);
        rd_chk("R3 read mask0", 8'h22, 8'h0F);
        wr(8'h20, 8'hFF);
        chk("R4 mask 0F write FF", cell_q, 16'h3CF5);
        wr(8'h20, 8'h00);
        chk("R4 mask 0F write 00", cell_q, 16'h3C05);
    endtask

    task automatic t_logic();
        @(negedge clk);
        logic_d = 16'h0300; logic_ld = 16'h0300;
        @(negedge clk);
        logic_d = '0; logic_ld = '0;
        chk("R5 logic load", cell_q, 16'h3F05);
        @(negedge clk);
        chk("R5 hold without enable", cell_q, 16'h3F05);
    endtask

    task automatic t_collide();
        @(negedge clk);
        cpu_addr = 8'h20; cpu_wdata = 8'hF0; cpu_we = 1'b1;
        logic_d = 16'h000A; logic_ld = 16'h00FF;
        @(negedge clk);
        cpu_we = 1'b0; logic_d = '0; logic_ld = '0;
        chk("R6 R7 collision", cell_q, 16'h3FFA);
        wr(8'h20, 8'h00);
        chk("R7 protected hold", cell_q, 16'h3F0A);
    endtask

    task automatic t_unmapped();
        rd_chk("R9 read 24h", 8'h24, 8'h00);
        rd_chk("R9 read 1Fh", 8'h1F, 8'h00);
        wr(8'h24, 8'hFF);
        wr(8'h1F, 8'hFF);
        chk("R9 unmapped write q", cell_q, 16'h3F0A);
        rd_chk("R9 mask0 intact", 8'h22, 8'h0F);
        rd_chk("R9 mask1 intact", 8'h23, 8'h00);
    endtask

    task automatic t_mask_grp1();
        wr(8'h23, 8'hFF);
        rd_chk("R3 read mask1", 8'h23, 8'hFF);
        wr(8'h21, 8'h00);
        chk("R4 group1 fully protected", cell_q, 16'h3F0A);
        wr(8'h20, 8'hF0);
        chk("R4 mask0 only on group0", cell_q, 16'h3FFA);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_full_write();
        t_mask();
        t_logic();
        t_collide();
        t_unmapped();
        t_mask_grp1();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule